// File: doc/BRIEF.md
# Multi-Channel Periodic Interrupt Timer

This block is a bank of independent 32-bit down-counters placed behind a single-cycle register port. Each channel is reloaded from its own load register. When a channel passes through zero it raises a sticky timeout flag and then starts counting again from the load value, so every channel is strictly periodic. A software driver that wants a single event must turn the channel off itself when the interrupt arrives.

A channel whose chain bit is set stops counting on the clock. It steps once for every timeout of the channel just below it. Two neighbours can therefore act as one wide counter. A single control bit for the whole module freezes all channels at once. The flags, each qualified by its channel's interrupt enable, are merged into one interrupt line.

A load written while a channel runs does not disturb the running count. It takes effect at the next reload, or when the channel is switched off and on again.

Top module: `tick_timer_bank`

## Requirements
- R1: After reset every channel register reads zero, the module-control word at offset 0x000 reads 0x2 (bit 1, the module freeze bit, is set), and `irq_o` is low.
- R2: Channel n occupies offsets 0x100+0x10*n: load at +0x0, current value at +0x4, control at +0x8, flag at +0x C. Only bit 1 of the module-control word is stored. Writes to the current value are ignored. Reads return zero at unmapped or misaligned offsets and at channel indices of NCH or above.
- R3: Writing control bit 0 (enable) from 0 to 1 copies the load value into the current value on that write's clock edge. The count then goes down by one per cycle, so a load of L gives a period of L+1 cycles.
- R4: On the step after the current value is zero, the channel sets its flag (flag bit 0) and reloads from the load register, and it keeps running.
- R5: Writing a 1 to flag bit 0 clears the flag. Writing a 0 leaves it unchanged. If a timeout falls in the same cycle as a clearing write, the flag ends up set.
- R6: A load written while the channel runs leaves the current count unchanged. The new value is used at the next reload.
- R7: A channel with enable at 0 holds its current value and never sets its flag.
- R8: While the module freeze bit is 1, no channel counts and no timeout occurs.
- R9: For a channel n of 1 or more, control bit 2 (chain) makes it step only in cycles in which channel n-1 times out. The chain bit of channel 0 has no effect.
- R10: `irq_o` is the OR over all channels of (flag AND control bit 1, interrupt enable).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | AW (12) | Byte address of the register access |
| we_i | input | 1 | Write strobe, taken on the rising clock edge |
| wdata_i | input | DW (32) | Write data |
| rdata_o | output | DW (32) | Combinational read data for `addr_i` |
| irq_o | output | 1 | Combined interrupt |

## Verification
Two events can meet in one cycle: a timeout setting a flag, and a software write of 1 clearing that same flag. The bench lets a running channel count down to zero and issues the clearing write on exactly the edge where the reload happens. It then expects the flag to read back as set and the count to show the reloaded value. A second collision, between a load write and a running count, is judged by reading the current value straight after the write and again after the following reload.

// File: rtl/ttb_pkg.sv
package ttb_pkg;
    typedef enum logic [1:0] {
        RS_LOAD = 2'd0,
        RS_CUR  = 2'd1,
        RS_CTRL = 2'd2,
        RS_FLAG = 2'd3
    } regsel_e;

    localparam int unsigned CTRL_EN_BIT  = 0;
    localparam int unsigned CTRL_IE_BIT  = 1;
    localparam int unsigned CTRL_CHN_BIT = 2;
    localparam int unsigned FREEZE_BIT   = 1;
    localparam int unsigned BANK_SHIFT   = 8;
    localparam int unsigned IDX_W        = 4;
endpackage

// File: rtl/ttb_decode.sv
module ttb_decode
    import ttb_pkg::*;
#(
    parameter int unsigned AW  = 12,
    parameter int unsigned NCH = 4
) (
    input  logic [AW-1:0]  addr_i,
    output logic           mcr_hit_o,
    output logic [NCH-1:0] ch_hit_o,
    output regsel_e        sel_o
);
    localparam int unsigned BANK_W = AW - BANK_SHIFT;

    logic             aligned;
    logic             in_bank;
    logic [IDX_W-1:0] idx;

    always_comb begin
        aligned   = (addr_i[1:0] == 2'b00);
        in_bank   = (addr_i[AW-1:BANK_SHIFT] == BANK_W'(1));
        idx       = addr_i[BANK_SHIFT-1:4];
        mcr_hit_o = (addr_i == '0);
        sel_o     = regsel_e'(addr_i[3:2]);
    end

    for (genvar i = 0; i < NCH; i++) begin : g_hit
        assign ch_hit_o[i] = aligned && in_bank && (idx == IDX_W'(i));
    end
endmodule

// File: rtl/ttb_channel.sv
module ttb_channel
    import ttb_pkg::*;
#(
    parameter int unsigned DW       = 32,
    parameter bit          CHAIN_OK = 1'b1
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          wr_i,
    input  regsel_e       sel_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          run_i,
    input  logic          prev_tick_i,
    output logic          tick_o,
    output logic          irq_o,
    output logic [DW-1:0] rdata_o
);
    typedef struct packed {
        logic [DW-1:0] load;
        logic [DW-1:0] cur;
        logic          en;
        logic          ie;
        logic          chn;
        logic          flag;
    } chan_t;

    chan_t s_d, s_q;
    logic  start_d, step_d, tick_d, chained_d;

    always_comb begin
        s_d       = s_q;
        chained_d = CHAIN_OK && s_q.chn;
        start_d   = wr_i && (sel_i == RS_CTRL) && wdata_i[CTRL_EN_BIT] && !s_q.en;
        step_d    = s_q.en && run_i && (chained_d ? prev_tick_i : 1'b1);
        tick_d    = step_d && (s_q.cur == '0);

        if (wr_i && sel_i == RS_LOAD) s_d.load = wdata_i;
        if (wr_i && sel_i == RS_CTRL) begin
            s_d.en  = wdata_i[CTRL_EN_BIT];
            s_d.ie  = wdata_i[CTRL_IE_BIT];
            s_d.chn = wdata_i[CTRL_CHN_BIT];
        end
        if (wr_i && sel_i == RS_FLAG && wdata_i[0]) s_d.flag = 1'b0;

        if (step_d) s_d.cur = tick_d ? s_q.load : s_q.cur - DW'(1);
        if (start_d) s_d.cur = s_q.load;
        if (tick_d) s_d.flag = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    always_comb begin
        tick_o  = tick_d;
        irq_o   = s_q.flag && s_q.ie;
        rdata_o = '0;
        case (sel_i)
            RS_LOAD: rdata_o = s_q.load;
            RS_CUR:  rdata_o = s_q.cur;
            RS_CTRL: begin
                rdata_o[CTRL_EN_BIT]  = s_q.en;
                rdata_o[CTRL_IE_BIT]  = s_q.ie;
                rdata_o[CTRL_CHN_BIT] = s_q.chn;
            end
            default: rdata_o[0] = s_q.flag;
        endcase
    end

    // R7: a stopped channel keeps its count unless it is being started
    a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!s_q.en && !start_d) |=> $stable(s_q.cur));

    // R4: a timeout reloads the count from the load register
    a_r4_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> (s_q.cur == $past(s_q.load)));

    // R4: a timeout leaves the flag set
    a_r4_flag_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> s_q.flag);

    // R5: without a register write the flag stays set
    a_r5_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.flag && !wr_i) |=> s_q.flag);

    // R9: a chained channel waits for its neighbour's timeout
    a_r9_chain_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (CHAIN_OK && s_q.chn && s_q.en && !prev_tick_i) |=> $stable(s_q.cur));
endmodule

// File: rtl/tick_timer_bank.sv
module tick_timer_bank
    import ttb_pkg::*;
#(
    parameter int unsigned AW  = 12,
    parameter int unsigned DW  = 32,
    parameter int unsigned NCH = 4
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [AW-1:0] addr_i,
    input  logic          we_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o,
    output logic          irq_o
);
    logic           mcr_hit;
    logic [NCH-1:0] ch_hit;
    regsel_e        sel;
    logic           freeze_d, freeze_q;
    logic [NCH-1:0] ch_tick;
    logic [NCH-1:0] ch_irq;
    logic [DW-1:0]  ch_rd [NCH];

    ttb_decode #(.AW(AW), .NCH(NCH)) i_decode (
        .addr_i    (addr_i),
        .mcr_hit_o (mcr_hit),
        .ch_hit_o  (ch_hit),
        .sel_o     (sel)
    );

    always_comb begin
        freeze_d = freeze_q;
        if (we_i && mcr_hit) freeze_d = wdata_i[FREEZE_BIT];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) freeze_q <= 1'b1;
        else         freeze_q <= freeze_d;
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic prev_tick;
        if (i == 0) begin : g_first
            assign prev_tick = 1'b0;
        end else begin : g_next
            assign prev_tick = ch_tick[i-1];
        end

        ttb_channel #(.DW(DW), .CHAIN_OK(i > 0)) i_chan (
            .clk_i       (clk_i),
            .rst_ni      (rst_ni),
            .wr_i        (we_i && ch_hit[i]),
            .sel_i       (sel),
            .wdata_i     (wdata_i),
            .run_i       (!freeze_q),
            .prev_tick_i (prev_tick),
            .tick_o      (ch_tick[i]),
            .irq_o       (ch_irq[i]),
            .rdata_o     (ch_rd[i])
        );
    end

    always_comb begin
        rdata_o = '0;
        if (mcr_hit) rdata_o[FREEZE_BIT] = freeze_q;
        for (int i = 0; i < NCH; i++) begin
            if (ch_hit[i]) rdata_o = rdata_o | ch_rd[i];
        end
        irq_o = |ch_irq;
    end

    // R8: a frozen module produces no timeout anywhere
    a_r8_frozen_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        freeze_q |-> (ch_tick == '0));

    // R2: the decoder never selects more than one channel
    a_r2_one_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(ch_hit));
endmodule

// File: tb/test_tick_timer_bank.sv
`timescale 1ns/1ps
module test_tick_timer_bank;
    typedef struct packed {
        logic [11:0] a;
        logic        w;
        logic [31:0] d;
        logic [31:0] e;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{12'h100, 1'b1, 32'h1234_5678, 32'h0},
        '{12'h100, 1'b0, 32'h0,         32'h1234_5678},
        '{12'h108, 1'b1, 32'h7,         32'h0},
        '{12'h104, 1'b0, 32'h0,         32'h1234_5678},
        '{12'h108, 1'b0, 32'h0,         32'h7},
        '{12'h104, 1'b1, 32'h0000_DEAD, 32'h0},
        '{12'h104, 1'b0, 32'h0,         32'h1234_5678},
        '{12'h0F0, 1'b0, 32'h0,         32'h0},
        '{12'h140, 1'b0, 32'h0,         32'h0},
        '{12'h000, 1'b1, 32'hFFFF_FFFF, 32'h0},
        '{12'h000, 1'b0, 32'h0,         32'h2},
        '{12'h10C, 1'b0, 32'h0,         32'h0},
        '{12'h108, 1'b1, 32'h0,         32'h0},
        '{12'h108, 1'b0, 32'h0,         32'h0},
        '{12'h102, 1'b0, 32'h0,         32'h0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    int          errors = 0;
    int          checks = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    tick_timer_bank i_tick_timer_bank (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .addr_i  (addr),
        .we_i    (we),
        .wdata_i (wdata),
        .rdata_o (rdata),
        .irq_o   (irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(12'h000, v); chk("R1 mcr", v, 32'h2);
        rd(12'h120, v); chk("R1 load", v, 32'h0);
        rd(12'h128, v); chk("R1 ctrl", v, 32'h0);
        rd(12'h13C, v); chk("R1 flag", v, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);

        // R2 register map walk, module frozen so nothing counts (R8)
        for (int k = 0; k < NV; k++) begin
            if (VECS[k].w) wr(VECS[k].a, VECS[k].d);
            else begin
                rd(VECS[k].a, v);
                chk("R2 map", v, VECS[k].e);
            end
        end

        // R3 enable loads, count down, period L+1
        wr(12'h120, 32'd5);
        wr(12'h000, 32'h0);
        wr(12'h128, 32'h3);
        rd(12'h124, v); chk("R3 start", v, 32'd5);
        idle(3);
        rd(12'h124, v); chk("R3 count", v, 32'd2);
        idle(2);
        rd(12'h124, v); chk("R3 zero", v, 32'd0);
        rd(12'h12C, v); chk("R3 no early flag", v, 32'd0);
        idle(1);
        rd(12'h124, v); chk("R4 reload", v, 32'd5);
        rd(12'h12C, v); chk("R4 flag", v, 32'd1);
        chk("R10 irq on", {31'b0, irq}, 32'h1);

        // R5 clearing by writing 1, writing 0 has no effect
        wr(12'h12C, 32'h1);
        rd(12'h12C, v); chk("R5 clear", v, 32'd0);
        chk("R10 irq off", {31'b0, irq}, 32'h0);
        idle(5);
        rd(12'h12C, v); chk("R4 periodic", v, 32'd1);
        wr(12'h12C, 32'h0);
        rd(12'h12C, v); chk("R5 write0", v, 32'd1);

        // R6 load write while running
        wr(12'h120, 32'd9);
        rd(12'h124, v); chk("R6 no restart", v, 32'd3);
        idle(4);
        rd(12'h124, v); chk("R6 new at reload", v, 32'd9);

        // R7 disabled channel holds
        wr(12'h128, 32'h0);
        rd(12'h124, v); chk("R7 stop", v, 32'd8);
        wr(12'h12C, 32'h1);
        idle(20);
        rd(12'h124, v); chk("R7 hold", v, 32'd8);
        rd(12'h12C, v); chk("R7 no flag", v, 32'd0);
        wr(12'h128, 32'h3);
        rd(12'h124, v); chk("R3 restart", v, 32'd9);

        // R8 module freeze
        wr(12'h000, 32'h2);
        idle(5);
        rd(12'h124, v); chk("R8 frozen", v, 32'd8);
        wr(12'h000, 32'h0);
        rd(12'h124, v); chk("R8 still", v, 32'd8);
        idle(1);
        rd(12'h124, v); chk("R8 resume", v, 32'd7);

        // R5 timeout and clear in the same cycle: set wins
        idle(7);
        rd(12'h124, v); chk("R5 at zero", v, 32'd0);
        wr(12'h12C, 32'h1);
        rd(12'h12C, v); chk("R5 set wins", v, 32'd1);
        rd(12'h124, v); chk("R5 reloaded", v, 32'd9);

        // R10 interrupt enable gating
        wr(12'h128, 32'h1);
        chk("R10 gated", {31'b0, irq}, 32'h0);
        wr(12'h128, 32'h3);
        chk("R10 ungated", {31'b0, irq}, 32'h1);
        wr(12'h128, 32'h0);
        wr(12'h12C, 32'h1);
        chk("R10 cleared", {31'b0, irq}, 32'h0);

        // R9 chaining channel 1 to channel 0
        wr(12'h100, 32'd2);
        wr(12'h110, 32'd1);
        wr(12'h118, 32'h5);
        wr(12'h108, 32'h1);
        idle(3);
        rd(12'h114, v); chk("R9 one step", v, 32'd0);
        rd(12'h11C, v); chk("R9 no flag", v, 32'd0);
        idle(2);
        rd(12'h114, v); chk("R9 waits", v, 32'd0);
        idle(1);
        rd(12'h11C, v); chk("R9 flag", v, 32'd1);
        rd(12'h114, v); chk("R9 reload", v, 32'd1);
        chk("R10 no ie", {31'b0, irq}, 32'h0);
        wr(12'h108, 32'h5);
        idle(1);
        rd(12'h104, v); chk("R9 ch0 chain ignored", v, 32'd0);

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule